// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vectoring

The arbiter gathers interrupt requests from two kinds of input and keeps them in a pending mask. The first kind is a set of peripheral status-flag and enable pairs. The second kind is a bus of direct raise lines, one per vector index. When the core signals an instruction boundary, the arbiter picks at most one pending request. It hands the core the request's vector index, the address to fetch the handler pointer from, and which of the core's two mask bits to set on entry. It then drops that request from the pending mask.

Selection follows a fixed ladder:

1. The software-trap index comes first, then the illegal-opcode index. Neither of these can be masked.
2. The non-maskable line comes next, gated only by its own mask bit. While it is pending and masked, nothing is selected.
3. If the general mask bit is clear, the maskable sources are scanned through a priority-order table that software can rewrite.

Stacking, the vector memory read and running the handler stay in the core.

The result leaves on a valid/ready channel. Once valid is raised, index, vector and mask-select hold steady until ready is seen high at a clock edge. While the slot is occupied, boundary strobes are ignored, so back-pressure simply delays the next selection. An evaluation that finds nothing to serve leaves valid low.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A peripheral pair makes its mapped index pending when its flag is 1 and its enable is 1. A pair built without an enable makes its index pending on the flag alone. By default pairs 0-3 map to index 20, and pairs 4, 5, 6 and 7 map to 21, 22, 23 and 24; pair 7 has no enable.
- R2: A 1 on raise_i bit k makes index k pending. Pending bits are sticky: a bit stays set until its index is selected, even after the request input falls.
- R3: Index 27 (software trap) is selected first and index 28 (illegal opcode) second, whatever the two mask inputs are.
- R4: Index 26 (non-maskable) is selected when nmask_i is 0. If it is pending while nmask_i is 1, and neither 27 nor 28 is pending, no index is selected.
- R5: While gmask_i is 1, no index other than 26, 27 or 28 is selected.
- R6: Maskable indices are scanned in the order of the order table, entry 0 first, and the first pending one is taken. After reset, entry i holds i. A write with ord_we_i high stores ord_data_i into entry ord_addr_i.
- R7: svc_vec_o equals 0xFFC0 plus twice svc_idx_o.
- R8: svc_set_nmask_o is 1 when the served index is 26, which tells the core to set its non-maskable mask. It is 0 otherwise, which means the general mask is to be set.
- R9: The selected index's pending bit is cleared in the cycle of selection, so each raise is served once.
- R10: svc_valid_o rises one clock after a boundary strobe that finds a selectable index. It stays high with a stable payload until a clock edge with svc_ready_i high. A strobe arriving while svc_valid_o is high is ignored and clears nothing.
- R11: raise_cnt_o increases by the number of raise_i bits that are high in each clock.
- R12: After reset, svc_valid_o is 0, raise_cnt_o is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | NUM_PAIR | Peripheral status flags |
| en_i | input | NUM_PAIR | Peripheral enable bits |
| raise_i | input | N_IDX | Direct raise line per index |
| gmask_i | input | 1 | Core general interrupt mask |
| nmask_i | input | 1 | Core non-maskable-line mask |
| eval_i | input | 1 | Instruction-boundary strobe |
| ord_we_i | input | 1 | Order-table write strobe |
| ord_addr_i | input | IDX_W | Order-table entry to write |
| ord_data_i | input | IDX_W | Index stored into the entry |
| svc_valid_o | output | 1 | Service result valid |
| svc_ready_i | input | 1 | Core accepts the result |
| svc_idx_o | output | IDX_W | Selected vector index |
| svc_vec_o | output | 16 | Vector fetch address |
| svc_set_nmask_o | output | 1 | 1: set non-maskable mask, 0: set general mask |
| raise_cnt_o | output | CNT_W | Running count of raise events |

## Verification
A raise or a flag pulse becomes pending one clock after the edge that samples it. A boundary strobe produces svc_valid_o and its payload one clock after the edge that takes it. Expected results are queued when the strobe is driven and popped by a monitor that samples just after each falling edge, only while valid and ready are both high. Empty evaluations, held payloads under back-pressure and counter values are checked at the falling edge that follows the relevant rising edge, where every register on the path has already updated.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int VEC_W = 16;

  // Handler pointers are 16-bit words, so indices step the address by two.
  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input logic [7:0] idx);
    return base + {7'b0, idx, 1'b0};
  endfunction

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int N_IDX = 32,
  parameter int NUM_PAIR = 8,
  parameter int IDX_W = 5,
  parameter logic [NUM_PAIR*IDX_W-1:0] PAIR_MAP = '0,
  parameter logic [NUM_PAIR-1:0] PAIR_HAS_EN = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_PAIR-1:0] flag_i,
  input  logic [NUM_PAIR-1:0] en_i,
  input  logic [N_IDX-1:0] raise_i,
  input  logic [N_IDX-1:0] clr_i,
  output logic [N_IDX-1:0] pend_o
);
  logic [N_IDX-1:0] pair_vec [NUM_PAIR];
  logic [N_IDX-1:0] new_req;
  logic [N_IDX-1:0] pend_q;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic hit;
    assign hit = flag_i[p] && (en_i[p] || !PAIR_HAS_EN[p]);
    assign pair_vec[p] = hit ? (N_IDX'(1) << PAIR_MAP[p*IDX_W +: IDX_W]) : '0;
  end

  always_comb begin
    new_req = raise_i;
    for (int p = 0; p < NUM_PAIR; p++) new_req = new_req | pair_vec[p];
  end

  // A fresh request in the clearing cycle survives the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | new_req;
  end

  assign pend_o = pend_q;

  assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));

endmodule

// File: rtl/irq_order_table.sv
module irq_order_table #(
  parameter int N_IDX = 32,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       addr_i,
  input  logic [IDX_W-1:0]       data_i,
  output logic [N_IDX*IDX_W-1:0] order_o
);
  logic [IDX_W-1:0] tbl_q [N_IDX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IDX; i++) tbl_q[i] <= IDX_W'(i);
    end else if (we_i) begin
      tbl_q[addr_i] <= data_i;
    end
  end

  for (genvar i = 0; i < N_IDX; i++) begin : g_flat
    assign order_o[i*IDX_W +: IDX_W] = tbl_q[i];
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int N_IDX = 32,
  parameter int IDX_W = 5,
  parameter int SWI_IDX = 27,
  parameter int ILL_IDX = 28,
  parameter int NMI_IDX = 26
) (
  input  logic [N_IDX-1:0]       pend_i,
  input  logic                   gmask_i,
  input  logic                   nmask_i,
  input  logic [N_IDX*IDX_W-1:0] order_i,
  output logic                   sel_valid_o,
  output logic [IDX_W-1:0]       sel_idx_o
);
  logic [IDX_W-1:0] entry;

  always_comb begin
    sel_valid_o = 1'b0;
    sel_idx_o   = '0;
    entry       = '0;
    if (pend_i[SWI_IDX]) begin
      sel_valid_o = 1'b1;
      sel_idx_o   = IDX_W'(SWI_IDX);
    end else if (pend_i[ILL_IDX]) begin
      sel_valid_o = 1'b1;
      sel_idx_o   = IDX_W'(ILL_IDX);
    end else if (pend_i[NMI_IDX]) begin
      // A masked non-maskable request stalls every lower source.
      if (!nmask_i) begin
        sel_valid_o = 1'b1;
        sel_idx_o   = IDX_W'(NMI_IDX);
      end
    end else if (!gmask_i) begin
      // Walk from the last entry down so the earliest entry wins.
      for (int i = N_IDX - 1; i >= 0; i--) begin
        entry = order_i[i*IDX_W +: IDX_W];
        if (pend_i[entry]) begin
          sel_valid_o = 1'b1;
          sel_idx_o   = entry;
        end
      end
    end
  end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_IDX = 32,
  parameter int NUM_PAIR = 8,
  parameter int CNT_W = 16,
  parameter int SWI_IDX = 27,
  parameter int ILL_IDX = 28,
  parameter int NMI_IDX = 26,
  parameter logic [15:0] VEC_BASE = 16'hFFC0,
  localparam int IDX_W = $clog2(N_IDX),
  parameter logic [NUM_PAIR*IDX_W-1:0] PAIR_MAP =
    {5'd24, 5'd23, 5'd22, 5'd21, 5'd20, 5'd20, 5'd20, 5'd20},
  parameter logic [NUM_PAIR-1:0] PAIR_HAS_EN = 8'b0111_1111
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PAIR-1:0] flag_i,
  input  logic [NUM_PAIR-1:0] en_i,
  input  logic [N_IDX-1:0]    raise_i,
  input  logic                gmask_i,
  input  logic                nmask_i,
  input  logic                eval_i,
  input  logic                ord_we_i,
  input  logic [IDX_W-1:0]    ord_addr_i,
  input  logic [IDX_W-1:0]    ord_data_i,
  output logic                svc_valid_o,
  input  logic                svc_ready_i,
  output logic [IDX_W-1:0]    svc_idx_o,
  output logic [VEC_W-1:0]    svc_vec_o,
  output logic                svc_set_nmask_o,
  output logic [CNT_W-1:0]    raise_cnt_o
);
  logic [N_IDX-1:0]       pend;
  logic [N_IDX-1:0]       clr;
  logic [N_IDX*IDX_W-1:0] order;
  logic                   sel_valid;
  logic [IDX_W-1:0]       sel_idx;
  logic                   take;

  logic                   valid_q;
  logic [IDX_W-1:0]       idx_q;
  logic [VEC_W-1:0]       vec_q;
  logic                   nm_q;
  logic [CNT_W-1:0]       cnt_q;

  irq_pending_reg #(
    .N_IDX(N_IDX), .NUM_PAIR(NUM_PAIR), .IDX_W(IDX_W),
    .PAIR_MAP(PAIR_MAP), .PAIR_HAS_EN(PAIR_HAS_EN)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
    .raise_i(raise_i), .clr_i(clr), .pend_o(pend)
  );

  irq_order_table #(.N_IDX(N_IDX), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst_n(rst_n), .we_i(ord_we_i), .addr_i(ord_addr_i),
    .data_i(ord_data_i), .order_o(order)
  );

  irq_select #(
    .N_IDX(N_IDX), .IDX_W(IDX_W),
    .SWI_IDX(SWI_IDX), .ILL_IDX(ILL_IDX), .NMI_IDX(NMI_IDX)
  ) u_sel (
    .pend_i(pend), .gmask_i(gmask_i), .nmask_i(nmask_i), .order_i(order),
    .sel_valid_o(sel_valid), .sel_idx_o(sel_idx)
  );

  // Strobes only land while the output slot is empty.
  assign take = eval_i && !valid_q && sel_valid;
  assign clr  = take ? (N_IDX'(1) << sel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
      nm_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        idx_q   <= sel_idx;
        vec_q   <= vec_of(VEC_BASE, 8'(sel_idx));
        nm_q    <= (sel_idx == IDX_W'(NMI_IDX));
      end else if (valid_q && svc_ready_i) begin
        valid_q <= 1'b0;
      end
      cnt_q <= cnt_q + CNT_W'($countones(raise_i));
    end
  end

  assign svc_valid_o     = valid_q;
  assign svc_idx_o       = idx_q;
  assign svc_vec_o       = vec_q;
  assign svc_set_nmask_o = nm_q;
  assign raise_cnt_o     = cnt_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !svc_ready_i) |=> (valid_q && $stable(idx_q) && $stable(vec_q)));

  assert_swi_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SWI_IDX] |-> (sel_valid && sel_idx == IDX_W'(SWI_IDX)));

  assert_nmi_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmask_i && pend[NMI_IDX] && !pend[SWI_IDX] && !pend[ILL_IDX]) |-> !sel_valid);

  assert_gmask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask_i && sel_valid) |-> (sel_idx == IDX_W'(SWI_IDX) ||
                                sel_idx == IDX_W'(ILL_IDX) ||
                                sel_idx == IDX_W'(NMI_IDX)));

endmodule

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  flag_i = '0;
  logic [7:0]  en_i = '0;
  logic [31:0] raise_i = '0;
  logic        gmask_i = 1'b0;
  logic        nmask_i = 1'b0;
  logic        eval_i = 1'b0;
  logic        ord_we_i = 1'b0;
  logic [4:0]  ord_addr_i = '0;
  logic [4:0]  ord_data_i = '0;
  logic        svc_ready_i = 1'b1;
  logic        svc_valid_o;
  logic [4:0]  svc_idx_o;
  logic [15:0] svc_vec_o;
  logic        svc_set_nmask_o;
  logic [15:0] raise_cnt_o;

  int checks = 0;
  int fails = 0;
  logic [21:0] sb_q [$];

  always #10 clk = ~clk;

  irq_vector_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
    .raise_i(raise_i), .gmask_i(gmask_i), .nmask_i(nmask_i),
    .eval_i(eval_i), .ord_we_i(ord_we_i), .ord_addr_i(ord_addr_i),
    .ord_data_i(ord_data_i), .svc_valid_o(svc_valid_o),
    .svc_ready_i(svc_ready_i), .svc_idx_o(svc_idx_o), .svc_vec_o(svc_vec_o),
    .svc_set_nmask_o(svc_set_nmask_o), .raise_cnt_o(raise_cnt_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each accepted result (R7 R8 R10).
  always begin
    @(negedge clk);
    #1;
    if (rst_n && svc_valid_o && svc_ready_i) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", {27'b0, svc_idx_o}, 32'hFFFF);
      end else begin
        logic [21:0] e;
        e = sb_q.pop_front();
        check(svc_idx_o == e[4:0], "R6 index", {27'b0, svc_idx_o}, {27'b0, e[4:0]});
        check(svc_vec_o == e[20:5], "R7 vector", {16'b0, svc_vec_o}, {16'b0, e[20:5]});
        check(svc_set_nmask_o == e[21], "R8 mask select",
              {31'b0, svc_set_nmask_o}, {31'b0, e[21]});
      end
    end
  end

  task automatic pulse_raise(input logic [31:0] m);
    @(negedge clk) raise_i = m;
    @(negedge clk) raise_i = '0;
  endtask

  task automatic pulse_flag(input int p, input bit en);
    @(negedge clk) begin flag_i[p] = 1'b1; en_i[p] = en; end
    @(negedge clk) begin flag_i[p] = 1'b0; en_i[p] = 1'b0; end
  endtask

  // Driver: queues the expected item, strobes, checks empty evaluations.
  task automatic eval_expect(input bit exp_v, input int idx, input bit nm,
                             input string req);
    if (exp_v) sb_q.push_back({nm, 16'hFFC0 + 16'(2 * idx), 5'(idx)});
    @(negedge clk) eval_i = 1'b1;
    @(negedge clk) eval_i = 1'b0;
    if (!exp_v) check(svc_valid_o == 1'b0, req, {31'b0, svc_valid_o}, 32'h0);
    @(negedge clk);
  endtask

  task automatic write_order(input int a, input int d);
    @(negedge clk) begin ord_we_i = 1'b1; ord_addr_i = 5'(a); ord_data_i = 5'(d); end
    @(negedge clk) ord_we_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(svc_valid_o == 1'b0, "R12 valid", {31'b0, svc_valid_o}, 0);
    check(raise_cnt_o == 16'd0, "R12 count", {16'b0, raise_cnt_o}, 0);
    eval_expect(1'b0, 0, 1'b0, "R12 nothing pending");

    // R1 peripheral pairs
    pulse_flag(5, 1'b1);
    eval_expect(1'b1, 22, 1'b0, "R1 pair5");
    pulse_flag(6, 1'b0);
    eval_expect(1'b0, 0, 1'b0, "R1 pair6 disabled");
    pulse_flag(7, 1'b0);
    eval_expect(1'b1, 24, 1'b0, "R1 pair7 no enable");
    pulse_flag(1, 1'b1);
    eval_expect(1'b1, 20, 1'b0, "R1 pair1 shared");

    // R2 sticky raise, R9 served once
    pulse_raise((32'd1 << 3) | (32'd1 << 10));
    repeat (2) @(negedge clk);
    eval_expect(1'b1, 3, 1'b0, "R2 first");
    eval_expect(1'b1, 10, 1'b0, "R2 second");
    eval_expect(1'b0, 0, 1'b0, "R9 cleared after service");

    // R3 traps ignore masks, R4 masked NMI stalls, R5 general mask
    @(negedge clk) begin gmask_i = 1'b1; nmask_i = 1'b1; end
    pulse_raise((32'd1 << 27) | (32'd1 << 28) | (32'd1 << 26) | (32'd1 << 5));
    eval_expect(1'b1, 27, 1'b0, "R3 software trap");
    eval_expect(1'b1, 28, 1'b0, "R3 illegal opcode");
    eval_expect(1'b0, 0, 1'b0, "R4 masked NMI");
    @(negedge clk) nmask_i = 1'b0;
    eval_expect(1'b1, 26, 1'b1, "R4 NMI served R8");
    eval_expect(1'b0, 0, 1'b0, "R5 general mask");
    @(negedge clk) gmask_i = 1'b0;
    eval_expect(1'b1, 5, 1'b0, "R5 unmasked");

    // R4 masked NMI blocks a lower maskable source
    @(negedge clk) nmask_i = 1'b1;
    pulse_raise((32'd1 << 26) | (32'd1 << 2));
    eval_expect(1'b0, 0, 1'b0, "R4 NMI blocks lower");
    @(negedge clk) nmask_i = 1'b0;
    eval_expect(1'b1, 26, 1'b1, "R4 NMI");
    eval_expect(1'b1, 2, 1'b0, "R4 lower after NMI");

    // R6 reprogrammed order: swap entries 0 and 9
    write_order(0, 9);
    write_order(9, 0);
    pulse_raise((32'd1 << 0) | (32'd1 << 9));
    eval_expect(1'b1, 9, 1'b0, "R6 reordered first");
    eval_expect(1'b1, 0, 1'b0, "R6 reordered second");

    // R10 back-pressure and busy strobe
    @(negedge clk) svc_ready_i = 1'b0;
    pulse_raise(32'd1 << 4);
    sb_q.push_back({1'b0, 16'hFFC0 + 16'd8, 5'd4});
    @(negedge clk) eval_i = 1'b1;
    @(negedge clk) eval_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(svc_valid_o == 1'b1, "R10 held valid", {31'b0, svc_valid_o}, 1);
      check(svc_idx_o == 5'd4, "R10 held index", {27'b0, svc_idx_o}, 4);
      @(negedge clk);
    end
    pulse_raise(32'd1 << 6);
    @(negedge clk) eval_i = 1'b1;
    @(negedge clk) eval_i = 1'b0;
    check(svc_idx_o == 5'd4, "R10 busy strobe ignored", {27'b0, svc_idx_o}, 4);
    svc_ready_i = 1'b1;
    @(negedge clk);
    check(svc_valid_o == 1'b0, "R10 released", {31'b0, svc_valid_o}, 0);
    eval_expect(1'b1, 6, 1'b0, "R10 pending kept through busy strobe");

    // R11 raise count: 2 + 4 + 2 + 2 + 1 + 1
    check(raise_cnt_o == 16'd12, "R11 count", {16'b0, raise_cnt_o}, 12);
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule